// File: doc/BRIEF.md
# Directory Home Controller for Cache Coherence

This block is the home-node side of a directory coherence scheme. It keeps, for every memory block it owns, a coherence state (Uncached, Shared or Exclusive), a bit vector naming the processors that hold a copy, and the block's memory contents. Caches send it three kinds of request: read miss, write miss and write-back. The controller answers with invalidations, fetch requests to an owner, and data replies. All channels use valid/ready handshakes and deliver messages in order.

Only one request is handled at a time. When a request is accepted, the controller works out every message it needs. It sends those messages one by one and accepts no new request until the final reply has been taken. A fetch to an owner waits for the owner's data on a separate return channel. That data is written to memory and then forwarded to the requester.

Top module: `coh_home_dir`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `msg_valid` is 0 and `fdat_ready` is 0. Every block starts Uncached with an empty sharer set and all-zero data, so the first read of any block replies with 0.
- R2: A read miss (`req_kind`=0) to an Uncached block produces one data reply (`msg_kind`=3) to the requester carrying the memory word. The block becomes Shared with the requester as its only sharer.
- R3: A read miss to a Shared block replies with the memory word and adds the requester to the sharer set. No other message is sent.
- R4: A write miss (`req_kind`=1) to an Uncached block replies with the memory word. The block becomes Exclusive, owned by the requester.
- R5: A write miss to a Shared block first sends one invalidate (`msg_kind`=0) to each sharer other than the requester, one per accepted message, in ascending processor number. It then sends the data reply. The block becomes Exclusive with the requester as sole owner.
- R6: A read miss to an Exclusive block sends a fetch (`msg_kind`=1) to the owner (the lowest-numbered set sharer bit). It waits for `fdat_valid`, writes the returned word to memory and replies with it. The block becomes Shared with both old owner and requester as sharers.
- R7: A write miss to an Exclusive block sends fetch-and-invalidate (`msg_kind`=2) to the owner. It writes the returned word to memory and replies with it to the requester. The block stays Exclusive, with the requester as sole owner.
- R8: A write-back (`req_kind`=2) stores `req_data` in memory, empties the sharer set and makes the block Uncached. It sends no message, and the controller is ready again in the next cycle.
- R9: From the acceptance of a read or write miss until its data reply is accepted, `req_ready` stays 0. No other request is taken, even if one is offered the whole time.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the offered message (kind, destination, block, data) stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and taking a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NPROC) | Requesting processor number |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DATA_W | Write-back data |
| fdat_valid | input | 1 | Owner data returned after a fetch |
| fdat_ready | output | 1 | Controller waiting for owner data |
| fdat_data | input | DATA_W | Returned owner data |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Interconnect takes the message |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_dst | output | $clog2(NPROC) | Destination processor |
| msg_blk | output | $clog2(NBLK) | Block index of the message |
| msg_data | output | DATA_W | Reply data (0 for other kinds) |

## Verification
The two functions that can meet in one cycle are the outgoing message sequence and the arrival of a new request. The bench provokes this by continuing to offer a write-back with poison data after a miss has been accepted. Meanwhile `msg_ready` is throttled by a pseudo-random pattern, which stretches invalidate bursts and fetch waits. It judges the result in two ways. First, `req_ready` must stay low on every sampled cycle of the sequence. Second, an arithmetic model of every block's state, sharers and data must keep matching all later replies, which would show the poison data if the early request had slipped in. A sweep of several hundred pseudo-random requests over four processors and four blocks reaches every state and request pair.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2
   } dstate_t;

   localparam logic [1:0] RQ_READ   = 2'd0;
   localparam logic [1:0] RQ_WRITE  = 2'd1;
   localparam logic [1:0] RQ_WBACK  = 2'd2;

   localparam logic [1:0] MS_INV    = 2'd0;
   localparam logic [1:0] MS_FETCH  = 2'd1;
   localparam logic [1:0] MS_FINV   = 2'd2;
   localparam logic [1:0] MS_DATA   = 2'd3;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] mask,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = |mask;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/dir_store.sv
module dir_store
   import dir_pkg::*;
#(
   parameter int NPROC  = 8,
   parameter int NBLK   = 16,
   parameter int DATA_W = 32,
   localparam int BW = $clog2(NBLK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BW-1:0]     blk,
   output dstate_t           rd_state,
   output logic [NPROC-1:0]  rd_sh,
   output logic [DATA_W-1:0] rd_mem,
   input  logic              wr_en,
   input  dstate_t           wr_state,
   input  logic [NPROC-1:0]  wr_sh,
   input  logic              mem_we,
   input  logic [DATA_W-1:0] mem_wdata
);
   dstate_t           st_a  [NBLK];
   logic [NPROC-1:0]  sh_a  [NBLK];
   logic [DATA_W-1:0] mem_a [NBLK];

   for (genvar b = 0; b < NBLK; b++) begin : g_ent
      dstate_t           st_q;
      logic [NPROC-1:0]  sh_q;
      logic [DATA_W-1:0] d_q;
      logic              hit;

      assign hit = (blk == BW'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= DS_UNC;
            sh_q <= '0;
            d_q  <= '0;
         end else begin
            if (wr_en && hit) begin
               st_q <= wr_state;
               sh_q <= wr_sh;
            end
            if (mem_we && hit) d_q <= mem_wdata;
         end
      end

      assign st_a[b]  = st_q;
      assign sh_a[b]  = sh_q;
      assign mem_a[b] = d_q;
   end

   assign rd_state = st_a[blk];
   assign rd_sh    = sh_a[blk];
   assign rd_mem   = mem_a[blk];
endmodule

// File: rtl/dir_engine.sv
module dir_engine
   import dir_pkg::*;
#(
   parameter int NPROC  = 8,
   parameter int NBLK   = 16,
   parameter int DATA_W = 32,
   localparam int PW = $clog2(NPROC),
   localparam int BW = $clog2(NBLK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [PW-1:0]     req_src,
   input  logic [BW-1:0]     req_blk,
   input  logic [DATA_W-1:0] req_data,
   input  logic              fdat_valid,
   output logic              fdat_ready,
   input  logic [DATA_W-1:0] fdat_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [1:0]        msg_kind,
   output logic [PW-1:0]     msg_dst,
   output logic [BW-1:0]     msg_blk,
   output logic [DATA_W-1:0] msg_data,
   output logic [BW-1:0]     st_blk,
   input  dstate_t           rd_state,
   input  logic [NPROC-1:0]  rd_sh,
   input  logic [DATA_W-1:0] rd_mem,
   output logic              wr_en,
   output dstate_t           wr_state,
   output logic [NPROC-1:0]  wr_sh,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata
);
   typedef enum logic [2:0] {
      E_IDLE, E_INV, E_FREQ, E_WAIT, E_REPLY
   } eng_t;

   eng_t              st_q, st_d;
   logic [PW-1:0]     src_q;
   logic [BW-1:0]     blk_q;
   logic              wr_q;
   logic [PW-1:0]     own_q;
   logic [NPROC-1:0]  inv_q, inv_d;
   logic [DATA_W-1:0] rep_q, rep_d;

   logic              own_any, inv_any;
   logic [PW-1:0]     own_idx, inv_idx;
   logic [NPROC-1:0]  req_oh, cur_oh, inv_left;
   logic              take;

   dir_lowbit #(.N(NPROC)) u_own (.mask(rd_sh), .any(own_any), .idx(own_idx));
   dir_lowbit #(.N(NPROC)) u_inv (.mask(inv_q), .any(inv_any), .idx(inv_idx));

   assign req_oh    = NPROC'(1) << req_src;
   assign cur_oh    = NPROC'(1) << src_q;
   assign inv_left  = rd_sh & ~req_oh;
   assign req_ready = (st_q == E_IDLE);
   assign take      = req_valid && req_ready;
   assign st_blk    = (st_q == E_IDLE) ? req_blk : blk_q;
   assign fdat_ready = (st_q == E_WAIT);

   always_comb begin
      st_d      = st_q;
      inv_d     = inv_q;
      rep_d     = rep_q;
      wr_en     = 1'b0;
      wr_state  = DS_UNC;
      wr_sh     = '0;
      mem_we    = 1'b0;
      mem_wdata = req_data;
      unique case (st_q)
         E_IDLE: begin
            if (req_valid) begin
               case (req_kind)
                  RQ_READ: begin
                     if (rd_state == DS_EXC) begin
                        st_d = E_FREQ;
                     end else begin
                        wr_en    = 1'b1;
                        wr_state = DS_SHR;
                        wr_sh    = (rd_state == DS_SHR) ? (rd_sh | req_oh) : req_oh;
                        rep_d    = rd_mem;
                        st_d     = E_REPLY;
                     end
                  end
                  RQ_WRITE: begin
                     if (rd_state == DS_EXC) begin
                        st_d = E_FREQ;
                     end else begin
                        wr_en    = 1'b1;
                        wr_state = DS_EXC;
                        wr_sh    = req_oh;
                        rep_d    = rd_mem;
                        if (rd_state == DS_SHR && inv_left != '0) begin
                           inv_d = inv_left;
                           st_d  = E_INV;
                        end else begin
                           st_d  = E_REPLY;
                        end
                     end
                  end
                  RQ_WBACK: begin
                     wr_en     = 1'b1;
                     wr_state  = DS_UNC;
                     wr_sh     = '0;
                     mem_we    = 1'b1;
                     mem_wdata = req_data;
                  end
                  default: ;
               endcase
            end
         end
         E_INV: begin
            if (msg_ready) begin
               inv_d = inv_q & ~(NPROC'(1) << inv_idx);
               if (inv_d == '0) st_d = E_REPLY;
            end
         end
         E_FREQ: begin
            if (msg_ready) st_d = E_WAIT;
         end
         E_WAIT: begin
            if (fdat_valid) begin
               wr_en     = 1'b1;
               wr_state  = wr_q ? DS_EXC : DS_SHR;
               wr_sh     = wr_q ? cur_oh : (rd_sh | cur_oh);
               mem_we    = 1'b1;
               mem_wdata = fdat_data;
               rep_d     = fdat_data;
               st_d      = E_REPLY;
            end
         end
         E_REPLY: begin
            if (msg_ready) st_d = E_IDLE;
         end
         default: st_d = E_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= E_IDLE;
         src_q <= '0;
         blk_q <= '0;
         wr_q  <= 1'b0;
         own_q <= '0;
         inv_q <= '0;
         rep_q <= '0;
      end else begin
         st_q  <= st_d;
         inv_q <= inv_d;
         rep_q <= rep_d;
         if (take) begin
            src_q <= req_src;
            blk_q <= req_blk;
            wr_q  <= (req_kind == RQ_WRITE);
            own_q <= own_idx;
         end
      end
   end

   always_comb begin
      msg_valid = 1'b0;
      msg_kind  = MS_DATA;
      msg_dst   = src_q;
      msg_blk   = blk_q;
      msg_data  = '0;
      case (st_q)
         E_INV: begin
            msg_valid = inv_any;
            msg_kind  = MS_INV;
            msg_dst   = inv_idx;
         end
         E_FREQ: begin
            msg_valid = 1'b1;
            msg_kind  = wr_q ? MS_FINV : MS_FETCH;
            msg_dst   = own_q;
         end
         E_REPLY: begin
            msg_valid = 1'b1;
            msg_kind  = MS_DATA;
            msg_data  = rep_q;
         end
         default: ;
      endcase
   end

   logic unused_ok;
   assign unused_ok = own_any;
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
   import dir_pkg::*;
#(
   parameter int NPROC  = 8,
   parameter int NBLK   = 16,
   parameter int DATA_W = 32,
   localparam int PW = $clog2(NPROC),
   localparam int BW = $clog2(NBLK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [PW-1:0]     req_src,
   input  logic [BW-1:0]     req_blk,
   input  logic [DATA_W-1:0] req_data,
   input  logic              fdat_valid,
   output logic              fdat_ready,
   input  logic [DATA_W-1:0] fdat_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [1:0]        msg_kind,
   output logic [PW-1:0]     msg_dst,
   output logic [BW-1:0]     msg_blk,
   output logic [DATA_W-1:0] msg_data
);
   if (NPROC < 2) begin : g_bad_nproc
      $error("coh_home_dir: NPROC must be at least 2");
   end
   if (NBLK < 2 || (NBLK & (NBLK - 1)) != 0) begin : g_bad_nblk
      $error("coh_home_dir: NBLK must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("coh_home_dir: DATA_W must be positive");
   end

   logic [BW-1:0]     st_blk;
   dstate_t           rd_state, wr_state;
   logic [NPROC-1:0]  rd_sh, wr_sh;
   logic [DATA_W-1:0] rd_mem, mem_wdata;
   logic              wr_en, mem_we;

   dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .blk(st_blk),
      .rd_state(rd_state), .rd_sh(rd_sh), .rd_mem(rd_mem),
      .wr_en(wr_en), .wr_state(wr_state), .wr_sh(wr_sh),
      .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   dir_engine #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
      .fdat_valid(fdat_valid), .fdat_ready(fdat_ready), .fdat_data(fdat_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_dst(msg_dst), .msg_blk(msg_blk), .msg_data(msg_data),
      .st_blk(st_blk), .rd_state(rd_state), .rd_sh(rd_sh), .rd_mem(rd_mem),
      .wr_en(wr_en), .wr_state(wr_state), .wr_sh(wr_sh),
      .mem_we(mem_we), .mem_wdata(mem_wdata)
   );
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int NPROC  = 8,
   parameter int NBLK   = 16,
   parameter int DATA_W = 32,
   localparam int PW = $clog2(NPROC),
   localparam int BW = $clog2(NBLK)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_kind,
   input logic              fdat_ready,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [1:0]        msg_kind,
   input logic [PW-1:0]     msg_dst,
   input logic [BW-1:0]     msg_blk,
   input logic [DATA_W-1:0] msg_data
);
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (req_ready && !msg_valid && !fdat_ready));

   a_r10_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=>
         (msg_valid && $stable(msg_kind) && $stable(msg_dst)
          && $stable(msg_blk) && $stable(msg_data)));

   a_r9_busy_msg: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready);

   a_r9_busy_wait: assert property (@(posedge clk) disable iff (!rst_n)
      fdat_ready |-> (!req_ready && !msg_valid));

   a_r5_inv_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && msg_kind == 2'd0) |=>
         (!(msg_valid && msg_kind == 2'd0) || (msg_dst > $past(msg_dst))));

   a_r6_fetch_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && (msg_kind == 2'd1 || msg_kind == 2'd2)) |=> fdat_ready);

   a_r8_wb_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 2'd2) |=> (req_ready && !msg_valid));
endmodule

bind coh_home_dir dir_home_chk #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_kind(req_kind), .fdat_ready(fdat_ready), .msg_valid(msg_valid),
   .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_dst(msg_dst),
   .msg_blk(msg_blk), .msg_data(msg_data)
);

// File: tb/test_coh_home_dir.sv
module test_coh_home_dir;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int NB = 4;
   localparam int DW = 8;
   localparam int PW = $clog2(NP);
   localparam int BW = $clog2(NB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic [PW-1:0] req_src = '0;
   logic [BW-1:0] req_blk = '0;
   logic [DW-1:0] req_data = '0;
   logic          fdat_valid = 1'b0;
   logic          fdat_ready;
   logic [DW-1:0] fdat_data = '0;
   logic          msg_valid;
   logic          msg_ready = 1'b1;
   logic [1:0]    msg_kind;
   logic [PW-1:0] msg_dst;
   logic [BW-1:0] msg_blk;
   logic [DW-1:0] msg_data;

   coh_home_dir #(.NPROC(NP), .NBLK(NB), .DATA_W(DW)) i_coh_home_dir (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
      .fdat_valid(fdat_valid), .fdat_ready(fdat_ready), .fdat_data(fdat_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_dst(msg_dst), .msg_blk(msg_blk), .msg_data(msg_data)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   int            m_st  [NB];
   logic [NP-1:0] m_sh  [NB];
   logic [DW-1:0] m_mem [NB];
   logic [DW-1:0] m_own [NB];
   int            ctr = 0;

   logic [1:0]    ek [16];
   int            ed [16];
   logic [DW-1:0] ev [16];
   int            ne;
   string         etag;
   logic [DW-1:0] fval;
   logic [DW-1:0] last_rep;
   logic [15:0]   lfsr = 16'hACE1;

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(logic [1:0] k, int d, logic [DW-1:0] v);
      ek[ne] = k; ed[ne] = d; ev[ne] = v; ne++;
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic model(int kind, int src, int blk, logic [DW-1:0] data);
      logic [NP-1:0] pb;
      int own;
      pb = NP'(1) << src;
      ne = 0;
      own = 0;
      for (int i = NP - 1; i >= 0; i--) if (m_sh[blk][i]) own = i;
      ctr++;
      if (kind == 0) begin
         if (m_st[blk] == 2) begin
            etag = "R6";
            push(2'd1, own, '0);
            fval = m_own[blk];
            m_mem[blk] = fval;
            push(2'd3, src, fval);
            m_sh[blk] = m_sh[blk] | pb;
         end else begin
            etag = (m_st[blk] == 0) ? "R2" : "R3";
            push(2'd3, src, m_mem[blk]);
            m_sh[blk] = (m_st[blk] == 0) ? pb : (m_sh[blk] | pb);
         end
         m_st[blk] = 1;
      end else if (kind == 1) begin
         if (m_st[blk] == 2) begin
            etag = "R7";
            push(2'd2, own, '0);
            fval = m_own[blk];
            m_mem[blk] = fval;
            push(2'd3, src, fval);
         end else begin
            etag = (m_st[blk] == 0) ? "R4" : "R5";
            if (m_st[blk] == 1)
               for (int i = 0; i < NP; i++)
                  if (m_sh[blk][i] && i != src) push(2'd0, i, '0);
            push(2'd3, src, m_mem[blk]);
         end
         m_sh[blk]  = pb;
         m_st[blk]  = 2;
         m_own[blk] = DW'(ctr * 7 + src + 1);
      end else begin
         etag = "R8";
         m_mem[blk] = data;
         m_st[blk]  = 0;
         m_sh[blk]  = '0;
      end
   endtask

   task automatic run_op(int kind, int src, int blk, logic [DW-1:0] data, bit press);
      int got, guard;
      bit fpend, fdone, stall, r9ok;
      logic [1:0] sk;
      logic [PW-1:0] sd;
      logic [BW-1:0] sb;
      logic [DW-1:0] sv;
      model(kind, src, blk, data);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = 2'(kind);
      req_src   = PW'(src);
      req_blk   = BW'(blk);
      req_data  = data;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      if (press && ne > 0) begin
         req_kind = 2'd2; req_src = '0; req_data = 8'hEE;
      end else begin
         req_valid = 1'b0;
      end
      got = 0; guard = 0; fpend = 0; fdone = 0; stall = 0; r9ok = 1;
      sk = '0; sd = '0; sb = '0; sv = '0;
      while (got < ne && guard < 100) begin
         @(negedge clk);
         guard++;
         step_lfsr();
         msg_ready = lfsr[0] | lfsr[3];
         if (fdone) begin fdat_valid = 1'b0; fdone = 0; end
         if (fpend) begin fdat_valid = 1'b1; fdat_data = fval; end
         if (fdat_valid && fdat_ready) begin fpend = 0; fdone = 1; end
         if (stall)
            chk(msg_valid && msg_kind == sk && msg_dst == sd && msg_blk == sb && msg_data == sv,
                "R10", "stalled message changed, kind", int'(msg_kind), int'(sk));
         if (req_ready) r9ok = 0;
         stall = msg_valid && !msg_ready;
         sk = msg_kind; sd = msg_dst; sb = msg_blk; sv = msg_data;
         if (msg_valid && msg_ready) begin
            chk(msg_kind == ek[got], etag, "message kind", int'(msg_kind), int'(ek[got]));
            chk(int'(msg_dst) == ed[got], etag, "message destination", int'(msg_dst), ed[got]);
            chk(int'(msg_blk) == blk, etag, "message block", int'(msg_blk), blk);
            if (ek[got] == 2'd3) begin
               chk(msg_data == ev[got], etag, "reply data", int'(msg_data), int'(ev[got]));
               last_rep = msg_data;
            end
            if (ek[got] == 2'd1 || ek[got] == 2'd2) fpend = 1;
            got++;
            if (got == ne) req_valid = 1'b0;
         end
      end
      req_valid = 1'b0;
      chk(got == ne, etag, "message count", got, ne);
      chk(r9ok, "R9", "req_ready high during sequence", 1, 0);
      @(negedge clk);
      fdat_valid = 1'b0;
      chk(req_ready && !msg_valid, (kind == 2) ? "R8" : "R9",
          "idle after request, req_ready", int'(req_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int kind, src, blk, own;
      logic [DW-1:0] d;
      for (int b = 0; b < NB; b++) begin
         m_st[b] = 0; m_sh[b] = '0; m_mem[b] = '0; m_own[b] = '0;
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
      chk(msg_valid == 1'b0, "R1", "msg_valid in reset", int'(msg_valid), 0);
      chk(fdat_ready == 1'b0, "R1", "fdat_ready in reset", int'(fdat_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !msg_valid, "R1", "idle after reset", int'(req_ready), 1);

      run_op(0, 1, 2, '0, 0);
      chk(last_rep == '0, "R1", "first read data", int'(last_rep), 0);
      run_op(0, 2, 2, '0, 0);
      run_op(0, 3, 2, '0, 1);
      run_op(1, 0, 2, '0, 1);
      run_op(0, 1, 2, '0, 1);
      run_op(1, 3, 2, '0, 1);
      run_op(1, 2, 2, '0, 0);
      run_op(2, 2, 2, m_own[2], 0);
      run_op(0, 0, 2, '0, 0);
      run_op(1, 1, 0, '0, 0);

      for (int n = 0; n < 600; n++) begin
         step_lfsr();
         kind = int'(lfsr[1:0]) % 3;
         src  = int'(lfsr[5:4]);
         blk  = int'(lfsr[9:8]);
         d    = '0;
         own  = 0;
         for (int i = NP - 1; i >= 0; i--) if (m_sh[blk][i]) own = i;
         if (m_st[blk] == 2 && src == own) kind = 2;
         if (kind == 2 && m_st[blk] != 2) kind = 0;
         if (kind == 2) begin src = own; d = m_own[blk]; end
         run_op(kind, src, blk, d, lfsr[12]);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule